// File: doc/BRIEF.md
# Switching-Gated Staged Configuration Register File

This block holds the byte-wide configuration of a power-stage controller. A simple request port carries one read or write per cycle, and every request is answered one cycle later with an ACK or a NACK. Each register belongs to a policy class that decides whether a write is accepted and when the written value reaches the active copy. The active copy is the one the rest of the chip uses. The class is judged against the live switching state. Switching counts as on when `sw_en_i` is high, and also when the always-on bit of the mode register is set.

Locked registers refuse writes while switching is on. Deferred fields accept writes into a staged copy and commit once switching stops. Power-up-only fields accept writes but take effect only through a save to the internal non-volatile image followed by a reload. A save command copies every readback value into the image. A reload, started by a command or by the `por_i` pulse, walks the image back one register per clock and applies the same gating rules.

The control state machine has three states. ST_IDLE serves bus requests. ST_STORE is entered from ST_IDLE when a save command is accepted; it writes one image entry per clock and returns to ST_IDLE after the last slot. ST_RESTORE is entered from ST_IDLE when a reload command is accepted, or from any state when `por_i` is high. It applies one slot per clock in ascending address order and returns to ST_IDLE after the last slot.

Top module: `stg_cfg_regs`

Register map (slot index in brackets; active byte of slot k is `act_cfg_o[8k+7:8k]`):

| Slot | Addr | Name | Class |
|---|---|---|---|
| 0 | 10h | MODE (bit0 = always-on) | immediate |
| 1–4 | 20h–23h | turn-on wait, turn-on ramp, turn-off wait, turn-off ramp | locked |
| 5 | 30h | OPCFG: [0] forced continuous, [2:1] voltage-control mode, [3] soft stop, [5:4] ready delay, [6] bus-address override, [7] aux-address override | [5:0] deferred, [7:6] power-up-only |
| 6 | 31h | BUSADR | power-up-only |
| 7 | 32h | AUXADR | deferred |
| 8 | 38h | VOFS | deferred only while active OPCFG[2:1] = 01, else immediate |
| 9–10 | 40h–41h | upper/lower maximum output code | locked |

Commands are write-only: 08h saves the registers to the image, and 09h reloads them (this address is locked).

## Requirements
- R1: After `rst_n` is released, every active byte and every readback byte is 00h, `busy_o` is low and `resp_valid_o` is low.
- R2: Every request is answered in the next cycle with `resp_valid_o` high. For a mapped register, a read returns ACK and the readback value, which is the most recently accepted written byte.
- R3: With switching off, an accepted write updates the active byte at the same clock edge. The MODE register is always immediate.
- R4: While switching is on (either `sw_en_i` = 1 or MODE[0] = 1), writes to slots 1–4, 9, 10 and to the reload command 09h are NACKed and leave the active bytes unchanged.
- R5: While switching is on, writes to OPCFG[5:0] and AUXADR are ACKed and stored in the staged copy only. The active bits keep their old values and readback shows the new byte.
- R6: At the first clock edge after switching goes from on to off, all staged deferred bits are copied to the active copy together. A write to a deferred register at that same edge leaves the written byte active.
- R7: VOFS is deferred when the active OPCFG[2:1] equals 01. Otherwise it is immediate, even while switching.
- R8: OPCFG[7:6] and BUSADR are ACKed and read back on write, but their active bits change only during a reload walk.
- R9: A write to 08h copies all readback bytes into the image. A write to 09h with switching off, or a `por_i` pulse (which first clears all active and readback bytes), reloads slots 0..10 one per clock in ascending address order. `busy_o` is high during either walk, and every request is NACKed while busy.
- R10: During a reload the MODE byte is restored first. If it sets always-on, the locked slots are skipped, and the deferred bits stay staged until always-on is cleared. Clearing it commits them as in R6.
- R11: Writes and reads to unmapped addresses, and reads of 08h or 09h, are NACKed with read data 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also clears the image |
| por_i | input | 1 | Power-up pulse: clears volatile state and starts a reload walk |
| sw_en_i | input | 1 | Power stage switching enable |
| bus_valid_i | input | 1 | Request strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| resp_valid_o | output | 1 | Response present (one cycle after request) |
| resp_ack_o | output | 1 | 1 = ACK, 0 = NACK |
| resp_rdata_o | output | 8 | Read data |
| busy_o | output | 1 | Save or reload walk in progress |
| act_cfg_o | output | 88 | Active bytes, slot k at bits 8k+7:8k |

## Verification
Two events can land on the same clock edge: the commit of staged deferred values when switching stops, and a bus write to a deferred register. The bench stages new OPCFG and AUXADR bytes while switching is on. It then drops `sw_en_i` in the same cycle as a fresh AUXADR write. The check expects the staged OPCFG and the freshly written AUXADR to be active together. A second pairing is the always-on bit restored in the first reload step against the locked and deferred slots that follow it in the same walk. That case is judged by which active bytes stay zero or staged after the walk.

// File: rtl/stg_cfg_pkg.sv
package stg_cfg_pkg;
    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NSLOT = 11;
    localparam int IW    = $clog2(NSLOT);

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;
    typedef logic [IW-1:0] idx_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESTORE = 2'd1,
        ST_STORE   = 2'd2
    } fsm_t;

    localparam addr_t CMD_STORE   = 8'h08;
    localparam addr_t CMD_RESTORE = 8'h09;

    localparam int MODE_IDX  = 0;
    localparam int OPCFG_IDX = 5;
    localparam int VOFS_IDX  = 8;

    // ascending addresses: the reload walk order depends on it
    localparam addr_t SLOT_ADDR [NSLOT] = '{
        8'h10, 8'h20, 8'h21, 8'h22, 8'h23, 8'h30,
        8'h31, 8'h32, 8'h38, 8'h40, 8'h41
    };
    localparam byte_t SLOT_DEF [NSLOT] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3F,
        8'h00, 8'hFF, 8'h00, 8'h00, 8'h00
    };
    localparam byte_t SLOT_NVO [NSLOT] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC0,
        8'hFF, 8'h00, 8'h00, 8'h00, 8'h00
    };
    localparam logic [NSLOT-1:0] SLOT_LOCK = 11'b110_0001_1110;

    function automatic logic [NSLOT*DW-1:0] lock_bits();
        logic [NSLOT*DW-1:0] v;
        v = '0;
        for (int i = 0; i < NSLOT; i++)
            if (SLOT_LOCK[i]) v[i*DW +: DW] = '1;
        return v;
    endfunction

    function automatic logic [NSLOT*DW-1:0] def_bits();
        logic [NSLOT*DW-1:0] v;
        for (int i = 0; i < NSLOT; i++) v[i*DW +: DW] = SLOT_DEF[i];
        return v;
    endfunction

    function automatic logic [NSLOT*DW-1:0] nvo_bits();
        logic [NSLOT*DW-1:0] v;
        for (int i = 0; i < NSLOT; i++) v[i*DW +: DW] = SLOT_NVO[i];
        return v;
    endfunction
endpackage

// File: rtl/stg_cfg_decode.sv
module stg_cfg_decode
    import stg_cfg_pkg::*;
(
    input  addr_t addr_i,
    output logic  hit_o,
    output idx_t  idx_o,
    output logic  is_store_o,
    output logic  is_restore_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (addr_i == SLOT_ADDR[i]) begin
                hit_o = 1'b1;
                idx_o = idx_t'(i);
            end
        end
        is_store_o   = (addr_i == CMD_STORE);
        is_restore_o = (addr_i == CMD_RESTORE);
    end
endmodule

// File: rtl/stg_cfg_slot.sv
module stg_cfg_slot
    import stg_cfg_pkg::*;
#(
    parameter byte_t DEF_MASK = '0,
    parameter byte_t NVO_MASK = '0,
    parameter bit    COND_DEF = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  commit_i,
    input  logic  sw_eff_i,
    input  logic  cond_on_i,
    input  logic  wr_i,
    input  logic  wr_restore_i,
    input  byte_t wr_data_i,
    output byte_t act_o,
    output byte_t shad_o
);
    localparam byte_t CMT_MASK = COND_DEF ? {DW{1'b1}} : DEF_MASK;

    byte_t act_q, shad_q, act_nxt, dm, base, upd;

    always_comb begin
        dm   = COND_DEF ? {DW{cond_on_i}} : DEF_MASK;
        base = commit_i ? ((act_q & ~CMT_MASK) | (shad_q & CMT_MASK)) : act_q;
        upd  = ~(dm | NVO_MASK)
             | (sw_eff_i ? byte_t'(0) : dm)
             | (wr_restore_i ? NVO_MASK : byte_t'(0));
        act_nxt = wr_i ? ((base & ~upd) | (wr_data_i & upd)) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            shad_q <= '0;
        end else if (clr_i) begin
            act_q  <= '0;
            shad_q <= '0;
        end else begin
            act_q <= act_nxt;
            if (wr_i) shad_q <= wr_data_i;
        end
    end

    assign act_o  = act_q;
    assign shad_o = shad_q;
endmodule

// File: rtl/stg_cfg_image.sv
module stg_cfg_image
    import stg_cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_i,
    input  idx_t  idx_i,
    input  byte_t wdata_i,
    output byte_t rdata_o
);
    byte_t mem_q [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/stg_cfg_regs.sv
module stg_cfg_regs
    import stg_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              sw_en_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic              resp_valid_o,
    output logic              resp_ack_o,
    output logic [DW-1:0]     resp_rdata_o,
    output logic              busy_o,
    output logic [NSLOT*DW-1:0] act_cfg_o
);
    localparam idx_t LAST_IDX = idx_t'(NSLOT - 1);

    fsm_t  state_q, state_nxt;
    idx_t  idx_q, idx_nxt;
    logic  sw_q, sw_eff, commit, cond_on;
    logic  hit, is_store, is_restore, is_cmd;
    idx_t  dec_idx;
    logic  req_ok, lock_hit, bus_wr_slot, rst_wr, nv_we;
    logic  ack_c;
    byte_t rdata_c, nv_rdata, wr_data;
    byte_t act [NSLOT];
    byte_t shad [NSLOT];
    logic [NSLOT-1:0] slot_wr;
    logic [NSLOT*DW-1:0] shad_flat;

    stg_cfg_decode u_dec (
        .addr_i      (bus_addr_i),
        .hit_o       (hit),
        .idx_o       (dec_idx),
        .is_store_o  (is_store),
        .is_restore_o(is_restore)
    );

    assign is_cmd  = is_store | is_restore;
    assign sw_eff  = sw_en_i | act[MODE_IDX][0];
    assign commit  = sw_q & ~sw_eff;
    assign cond_on = (act[OPCFG_IDX][2:1] == 2'b01);
    assign busy_o  = (state_q != ST_IDLE);

    always_comb begin
        req_ok      = bus_valid_i && (state_q == ST_IDLE) && !por_i;
        lock_hit    = hit && SLOT_LOCK[dec_idx];
        bus_wr_slot = req_ok && bus_write_i && hit && !(lock_hit && sw_eff);
        rst_wr      = (state_q == ST_RESTORE) && !por_i
                      && !(SLOT_LOCK[idx_q] && sw_eff);
        nv_we       = (state_q == ST_STORE) && !por_i;
        wr_data     = (state_q == ST_RESTORE) ? nv_rdata : bus_wdata_i;
        ack_c       = 1'b0;
        rdata_c     = '0;
        if (req_ok) begin
            if (bus_write_i)
                ack_c = (hit && !(lock_hit && sw_eff)) || is_store
                        || (is_restore && !sw_eff);
            else if (hit) begin
                ack_c   = 1'b1;
                rdata_c = shad[dec_idx];
            end
        end
        for (int i = 0; i < NSLOT; i++)
            slot_wr[i] = (bus_wr_slot && dec_idx == idx_t'(i))
                       || (rst_wr && idx_q == idx_t'(i));
    end

    // next-state process
    always_comb begin
        state_nxt = state_q;
        idx_nxt   = idx_q;
        if (por_i) begin
            state_nxt = ST_RESTORE;
            idx_nxt   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_ok && bus_write_i && is_store) begin
                        state_nxt = ST_STORE;
                        idx_nxt   = '0;
                    end else if (req_ok && bus_write_i && is_restore && !sw_eff) begin
                        state_nxt = ST_RESTORE;
                        idx_nxt   = '0;
                    end
                end
                ST_RESTORE, ST_STORE: begin
                    if (idx_q == LAST_IDX) begin
                        state_nxt = ST_IDLE;
                        idx_nxt   = '0;
                    end else begin
                        idx_nxt = idx_q + idx_t'(1);
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sw_q    <= 1'b0;
        end else begin
            state_q <= state_nxt;
            idx_q   <= idx_nxt;
            sw_q    <= sw_eff;
        end
    end

    // response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid_o <= 1'b0;
            resp_ack_o   <= 1'b0;
            resp_rdata_o <= '0;
        end else begin
            resp_valid_o <= bus_valid_i;
            resp_ack_o   <= ack_c;
            resp_rdata_o <= rdata_c;
        end
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            stg_cfg_slot #(
                .DEF_MASK(SLOT_DEF[g]),
                .NVO_MASK(SLOT_NVO[g]),
                .COND_DEF(g == VOFS_IDX)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .clr_i       (por_i),
                .commit_i    (commit),
                .sw_eff_i    (sw_eff),
                .cond_on_i   (cond_on),
                .wr_i        (slot_wr[g]),
                .wr_restore_i(state_q == ST_RESTORE),
                .wr_data_i   (wr_data),
                .act_o       (act[g]),
                .shad_o      (shad[g])
            );
            assign act_cfg_o[g*DW +: DW] = act[g];
            assign shad_flat[g*DW +: DW] = shad[g];
        end
    endgenerate

    stg_cfg_image u_img (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (nv_we),
        .idx_i  (idx_q),
        .wdata_i(shad[idx_q]),
        .rdata_o(nv_rdata)
    );
endmodule

// File: rtl/stg_cfg_regs_chk.sv
module stg_cfg_regs_chk
    import stg_cfg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 por_i,
    input logic                 bus_valid_i,
    input logic                 resp_valid_o,
    input logic                 resp_ack_o,
    input logic                 busy_o,
    input logic                 sw_eff,
    input logic                 sw_q,
    input logic                 hit,
    input logic                 is_cmd,
    input logic [NSLOT*DW-1:0]  act_cfg_o,
    input logic [NSLOT*DW-1:0]  shad_flat
);
    localparam logic [NSLOT*DW-1:0] LOCKB = lock_bits();
    localparam logic [NSLOT*DW-1:0] DEFB  = def_bits();
    localparam logic [NSLOT*DW-1:0] NVOB  = nvo_bits();

    // R2
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_i |=> resp_valid_o);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_eff && !por_i) |=> $stable(act_cfg_o & LOCKB));

    // R5
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_eff && !por_i) |=> $stable(act_cfg_o & DEFB));

    // R6
    commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q && !sw_eff && !por_i) |=> ((act_cfg_o & DEFB) == (shad_flat & DEFB)));

    // R8
    nvonly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !por_i) |=> $stable(act_cfg_o & NVOB));

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && busy_o) |=> !resp_ack_o);

    // R11
    unmapped_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && !busy_o && !por_i && !hit && !is_cmd) |=> !resp_ack_o);
endmodule

bind stg_cfg_regs stg_cfg_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_i       (por_i),
    .bus_valid_i (bus_valid_i),
    .resp_valid_o(resp_valid_o),
    .resp_ack_o  (resp_ack_o),
    .busy_o      (busy_o),
    .sw_eff      (sw_eff),
    .sw_q        (sw_q),
    .hit         (hit),
    .is_cmd      (is_cmd),
    .act_cfg_o   (act_cfg_o),
    .shad_flat   (shad_flat)
);

// File: tb/sim_stg_cfg_regs.sv
module sim_stg_cfg_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_i = 1'b0;
    logic        sw_en_i = 1'b0;
    logic        bus_valid_i = 1'b0;
    logic        bus_write_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [7:0]  bus_wdata_i = '0;
    logic        resp_valid_o, resp_ack_o, busy_o;
    logic [7:0]  resp_rdata_o;
    logic [87:0] act_cfg_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stg_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .por_i(por_i), .sw_en_i(sw_en_i),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .resp_valid_o(resp_valid_o), .resp_ack_o(resp_ack_o),
        .resp_rdata_o(resp_rdata_o), .busy_o(busy_o), .act_cfg_o(act_cfg_o)
    );

    function automatic logic [7:0] slot(input int k);
        return act_cfg_o[8*k +: 8];
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        output logic ack, output logic [7:0] rd);
        bus_valid_i = 1'b1; bus_write_i = wr; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        ack = resp_ack_o; rd = resp_rdata_o;
        bus_valid_i = 1'b0; bus_write_i = 1'b0;
    endtask

    task automatic t_reset();
        logic a; logic [7:0] r;
        chk("R1 act_all_zero", {7'd0, act_cfg_o == 88'd0}, 8'd1);
        chk("R1 busy", {7'd0, busy_o}, 8'd0);
        chk("R1 resp_valid", {7'd0, resp_valid_o}, 8'd0);
        xfer(1'b0, 8'h30, 8'h00, a, r);
        chk("R2 resp_valid", {7'd0, resp_valid_o}, 8'd1);
        chk("R1 read ack", {7'd0, a}, 8'd1);
        chk("R1 read data", r, 8'h00);
    endtask

    task automatic t_immediate();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h20, 8'h5A, a, r);
        chk("R3 ack", {7'd0, a}, 8'd1);
        chk("R3 active", slot(1), 8'h5A);
        xfer(1'b0, 8'h20, 8'h00, a, r);
        chk("R2 readback", r, 8'h5A);
    endtask

    task automatic t_locked();
        logic a; logic [7:0] r;
        sw_en_i = 1'b1;
        xfer(1'b1, 8'h20, 8'h33, a, r);
        chk("R4 nack", {7'd0, a}, 8'd0);
        chk("R4 active kept", slot(1), 8'h5A);
        xfer(1'b1, 8'h41, 8'h77, a, r);
        chk("R4 nack max", {7'd0, a}, 8'd0);
        chk("R4 max kept", slot(10), 8'h00);
        xfer(1'b1, 8'h09, 8'h00, a, r);
        chk("R4 reload nack", {7'd0, a}, 8'd0);
        chk("R4 not busy", {7'd0, busy_o}, 8'd0);
    endtask

    task automatic t_deferred();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h30, 8'h2B, a, r);
        chk("R5 ack", {7'd0, a}, 8'd1);
        xfer(1'b1, 8'h32, 8'h7C, a, r);
        chk("R5 opcfg held", slot(5), 8'h00);
        chk("R5 aux held", slot(7), 8'h00);
        xfer(1'b0, 8'h30, 8'h00, a, r);
        chk("R5 readback staged", r, 8'h2B);
        sw_en_i = 1'b0;
        cyc(1);
        chk("R6 opcfg commit", slot(5), 8'h2B);
        chk("R6 aux commit", slot(7), 8'h7C);
    endtask

    task automatic t_cond();
        logic a; logic [7:0] r;
        sw_en_i = 1'b1;
        xfer(1'b1, 8'h38, 8'h11, a, r);
        chk("R7 staged when mode01", slot(8), 8'h00);
        sw_en_i = 1'b0;
        cyc(1);
        chk("R7 commit", slot(8), 8'h11);
        xfer(1'b1, 8'h30, 8'h00, a, r);
        chk("R3 opcfg off", slot(5), 8'h00);
        sw_en_i = 1'b1;
        xfer(1'b1, 8'h38, 8'h22, a, r);
        chk("R7 immediate when mode00", slot(8), 8'h22);
    endtask

    task automatic t_collide();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h30, 8'h04, a, r);
        xfer(1'b1, 8'h32, 8'h44, a, r);
        chk("R5 aux old", slot(7), 8'h7C);
        sw_en_i = 1'b0;
        xfer(1'b1, 8'h32, 8'h99, a, r);
        chk("R6 same-edge opcfg", slot(5), 8'h04);
        chk("R6 same-edge aux", slot(7), 8'h99);
    endtask

    task automatic t_nvonly();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h31, 8'h5D, a, r);
        chk("R8 ack", {7'd0, a}, 8'd1);
        chk("R8 busadr inactive", slot(6), 8'h00);
        xfer(1'b1, 8'h30, 8'hC4, a, r);
        chk("R8 override bits inactive", slot(5), 8'h04);
        xfer(1'b0, 8'h31, 8'h00, a, r);
        chk("R8 readback", r, 8'h5D);
    endtask

    task automatic t_store_por();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h08, 8'h00, a, r);
        chk("R9 store ack", {7'd0, a}, 8'd1);
        chk("R9 busy store", {7'd0, busy_o}, 8'd1);
        cyc(13);
        por_i = 1'b1;
        cyc(1);
        por_i = 1'b0;
        chk("R9 busy restore", {7'd0, busy_o}, 8'd1);
        xfer(1'b0, 8'h20, 8'h00, a, r);
        chk("R9 nack busy", {7'd0, a}, 8'd0);
        cyc(14);
        chk("R9 idle", {7'd0, busy_o}, 8'd0);
        chk("R9 ton", slot(1), 8'h5A);
        chk("R8 opcfg full", slot(5), 8'hC4);
        chk("R8 busadr", slot(6), 8'h5D);
        chk("R9 aux", slot(7), 8'h99);
        chk("R9 vofs", slot(8), 8'h22);
    endtask

    task automatic t_reload_cmd();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h20, 8'h10, a, r);
        chk("R3 ton new", slot(1), 8'h10);
        xfer(1'b1, 8'h09, 8'h00, a, r);
        chk("R9 reload ack", {7'd0, a}, 8'd1);
        cyc(13);
        chk("R9 ton reloaded", slot(1), 8'h5A);
    endtask

    task automatic t_always_on();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h10, 8'h01, a, r);
        xfer(1'b1, 8'h20, 8'h77, a, r);
        chk("R4 always-on nack", {7'd0, a}, 8'd0);
        xfer(1'b1, 8'h08, 8'h00, a, r);
        cyc(13);
        por_i = 1'b1;
        cyc(1);
        por_i = 1'b0;
        cyc(14);
        chk("R10 mode", slot(0), 8'h01);
        chk("R10 locked skipped", slot(1), 8'h00);
        chk("R10 opcfg staged", slot(5), 8'hC0);
        chk("R10 busadr", slot(6), 8'h5D);
        chk("R10 aux staged", slot(7), 8'h00);
        chk("R10 vofs", slot(8), 8'h22);
        xfer(1'b0, 8'h32, 8'h00, a, r);
        chk("R10 aux readback", r, 8'h99);
        xfer(1'b1, 8'h10, 8'h00, a, r);
        cyc(1);
        chk("R10 opcfg commit", slot(5), 8'hC4);
        chk("R10 aux commit", slot(7), 8'h99);
    endtask

    task automatic t_unmapped();
        logic a; logic [7:0] r;
        xfer(1'b1, 8'h77, 8'hAA, a, r);
        chk("R11 wr nack", {7'd0, a}, 8'd0);
        xfer(1'b0, 8'h77, 8'h00, a, r);
        chk("R11 rd nack", {7'd0, a}, 8'd0);
        chk("R11 rd zero", r, 8'h00);
        xfer(1'b0, 8'h08, 8'h00, a, r);
        chk("R11 cmd rd nack", {7'd0, a}, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_locked();
        t_deferred();
        t_cond();
        t_collide();
        t_nvonly();
        t_store_por();
        t_reload_cmd();
        t_always_on();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule